// File: doc/BRIEF.md
# Terminal Line Command and Status Unit

This block holds the per-line state of a bank of terminal lines: a received character, a character waiting to be sent, and six status bits for each line. A processor drives it with 24-bit output command words and 24-bit skip-test words. The line side reports character arrivals, new connections and per-line resets. The block answers with one-cycle event strobes for a separate interrupt flag scanner, a one-cycle start pulse for each line's transmit, and a combinational skip decision.

A configuration input picks one of two operating modes. In mode A, control bit 13 of a command enables the line when set. In mode B, the same bit drops the data-terminal-ready signal when set. On a connected line this hangs the line up. Each line has its own transmit timer, and the line counts as busy from the start pulse until the timer runs out. The timer length is a parameter.

Status read-out uses these bit positions: bit 0 line enabled, bit 1 transmit interrupt enable, bit 2 character pending, bit 3 overrun, bit 4 carrier on, bit 5 data set ready. Event strobe index is line*4+kind, where kind 0 is receive, 1 is transmit done, 2 is carrier on and 3 is carrier off.

Top module: `termline_ctl`

## Requirements
- R1: After synchronous reset, every line's status, receive buffer and transmit buffer read zero, no line is busy, and tx_start, evt_set and evt_clr are all zero.
- R2: In a command word, bits 4..0 pick the line, bits 23..16 hold the character, bit 15 is no-transmit and bit 14 is the transmit interrupt enable. A command that takes the enable path writes bit 14 into status bit 1 and sets status bit 0. If bit 15 is clear, the same command also stores the character in the transmit buffer and raises that line's tx_start bit for the next cycle. The line then reads busy for exactly TX_TICKS cycles.
- R3: In mode A (mode_b=0), bit 13 set selects the enable path. With bit 13 clear, only status bit 0 is cleared, and nothing is stored or started.
- R4: In mode B, bit 13 clear selects the enable path. Bit 13 set on a connected line sets the status to 0x30 and cancels the timer. It also strobes evt_clr for kinds 0, 1 and 2 and evt_set for kind 3 of that line. Bit 13 set on a line that is not connected only clears status bit 0.
- R5: An enable-path command with bit 15 set leaves the transmit buffer and timer alone but still updates bits 0 and 1. At most one tx_start bit is high in any cycle.
- R6: A character arrival sets overrun (bit 3) if character pending (bit 2) is already set, and sets bit 2 otherwise. It stores the character, or 0 when rx_break is high, and strobes the receive event for that line.
- R7: rd_ack clears bits 2 and 3 of the line on rd_line. An acknowledge takes effect before an arrival on the same line in the same cycle.
- R8: When a line's timer runs out, the transmit event strobes only if status bit 1 is set at that moment.
- R9: In mode B, a connection on a line with bit 0 set sets bits 4 and 5 and strobes carrier-on. In mode A, or on a disabled line, a connection changes nothing.
- R10: In mode B, the skip word has line in bits 4..0 and requests transmit-buffer-empty (bit 9), carrier-on (bit 8) and data-set-ready (bit 7). skip_take is high only if at least one condition is requested and all requested conditions hold.
- R11: In mode A, the skip word has line in bits 11..7, and skip_take is high exactly when that line is not busy.
- R12: A line reset sets the status to 0x30 if the line is connected and 0 if it is not. It cancels the timer and strobes evt_clr for all four kinds of that line. Clears take precedence over sets in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b | input | 1 | Mode select: 0 mode A, 1 mode B |
| connected | input | NUM_LINES | Per-line connection state |
| cmd_valid | input | 1 | Command word valid |
| cmd_word | input | 24 | Output command word |
| rx_valid | input | 1 | Character arrival |
| rx_line | input | LINE_W | Arrival line |
| rx_char | input | 8 | Arrived character |
| rx_break | input | 1 | Arrival is a break |
| conn_valid | input | 1 | New connection event |
| conn_line | input | LINE_W | Connected line |
| lrst_valid | input | 1 | Per-line reset request |
| lrst_line | input | LINE_W | Line to reset |
| rd_line | input | LINE_W | Line shown on the read port |
| rd_ack | input | 1 | Acknowledge receive on rd_line |
| rd_status | output | 6 | Status of rd_line |
| rd_rbuf | output | 8 | Receive buffer of rd_line |
| rd_xbuf | output | 8 | Transmit buffer of rd_line |
| rd_tx_busy | output | 1 | Timer running on rd_line |
| skip_word | input | 24 | Skip-test word |
| skip_take | output | 1 | Skip decision |
| tx_start | output | NUM_LINES | Per-line transmit start pulse |
| evt_set | output | NUM_LINES*4 | Event flag set strobes |
| evt_clr | output | NUM_LINES*4 | Event flag clear strobes |

## Verification
Random command words cover every combination of the no-transmit, interrupt-enable and control bits in both modes. This separates the enable path, the mode-A disable, the mode-B hang-up on connected lines and the mode-B hang-up on unconnected lines. Arrivals, acknowledges, connections and line resets are mixed on a few lines so that repeat arrivals exercise overrun and break handling. Timers expire with interrupt enable both on and off, and some expire while a hang-up or reset cancels them. Random skip words are checked in both field layouts against a model of busy, carrier and data-set-ready, including words that request no condition.

// File: rtl/termline_pkg.sv
package termline_pkg;

    localparam int WORD_W       = 24;
    localparam int CHAR_W       = 8;
    localparam int CMD_CHAR_LSB = 16;
    localparam int CMD_NOXMT    = 15;
    localparam int CMD_XIE      = 14;
    localparam int CMD_CTL      = 13;
    localparam int SKB_XBE      = 9;
    localparam int SKB_CRO      = 8;
    localparam int SKB_DSR      = 7;
    localparam int SKA_LINE_LSB = 7;

    typedef enum logic [1:0] {
        EV_RX   = 2'd0,
        EV_TX   = 2'd1,
        EV_CON  = 2'd2,
        EV_COFF = 2'd3
    } ev_kind_e;
    localparam int EV_COUNT = 4;

    typedef struct packed {
        logic dsr;
        logic carrier;
        logic overrun;
        logic pending;
        logic txie;
        logic enabled;
    } line_stat_t;

    typedef struct packed {
        logic [CHAR_W-1:0] ch;
        logic              no_xmt;
        logic              xie;
        logic              ctl;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.ch     = w[CMD_CHAR_LSB +: CHAR_W];
        c.no_xmt = w[CMD_NOXMT];
        c.xie    = w[CMD_XIE];
        c.ctl    = w[CMD_CTL];
        return c;
    endfunction

    function automatic line_stat_t idle_stat(input logic conn);
        line_stat_t s;
        s         = '0;
        s.carrier = conn;
        s.dsr     = conn;
        return s;
    endfunction

endpackage

// File: rtl/termline_tx_timer.sv
module termline_tx_timer #(
    parameter int TICKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start)         cnt <= CW'(TICKS);
        else if (cancel)        cnt <= '0;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !start && !cancel;
endmodule

// File: rtl/termline_lane.sv
module termline_lane
    import termline_pkg::*;
#(
    parameter int TICKS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_b,
    input  logic                connected,
    input  logic                ack_hit,
    input  logic                rx_hit,
    input  logic [CHAR_W-1:0]   rx_char,
    input  logic                conn_hit,
    input  logic                cmd_hit,
    input  cmd_t                cmd,
    input  logic                lrst_hit,
    output line_stat_t          stat,
    output logic [CHAR_W-1:0]   rbuf,
    output logic [CHAR_W-1:0]   xbuf,
    output logic                tx_busy,
    output logic                tx_start,
    output logic [EV_COUNT-1:0] ev_set,
    output logic [EV_COUNT-1:0] ev_clr
);
    line_stat_t          nxt;
    logic [CHAR_W-1:0]   nrb, nxb;
    logic                start_n, cancel_n, tx_done;
    logic [EV_COUNT-1:0] set_n, clr_n;
    logic                en_path;

    // Mode A enables on ctl=1, mode B enables on ctl=0
    assign en_path = mode_b ^ cmd.ctl;

    termline_tx_timer #(.TICKS(TICKS)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start_n),
        .cancel (cancel_n),
        .busy   (tx_busy),
        .done   (tx_done)
    );

    always_comb begin
        nxt      = stat;
        nrb      = rbuf;
        nxb      = xbuf;
        start_n  = 1'b0;
        cancel_n = 1'b0;
        set_n    = '0;
        clr_n    = '0;
        if (ack_hit) begin
            nxt.pending = 1'b0;
            nxt.overrun = 1'b0;
        end
        if (rx_hit) begin
            if (nxt.pending) nxt.overrun = 1'b1;
            else             nxt.pending = 1'b1;
            nrb           = rx_char;
            set_n[EV_RX]  = 1'b1;
        end
        if (conn_hit && mode_b && stat.enabled) begin
            nxt.carrier   = 1'b1;
            nxt.dsr       = 1'b1;
            set_n[EV_CON] = 1'b1;
        end
        if (cmd_hit) begin
            if (en_path) begin
                if (!cmd.no_xmt) begin
                    nxb     = cmd.ch;
                    start_n = 1'b1;
                end
                nxt.txie    = cmd.xie;
                nxt.enabled = 1'b1;
            end else if (mode_b && connected) begin
                nxt            = idle_stat(1'b1);
                cancel_n       = 1'b1;
                clr_n[EV_RX]   = 1'b1;
                clr_n[EV_TX]   = 1'b1;
                clr_n[EV_CON]  = 1'b1;
                set_n[EV_COFF] = 1'b1;
            end else begin
                nxt.enabled = 1'b0;
            end
        end
        if (tx_done && stat.txie) set_n[EV_TX] = 1'b1;
        if (lrst_hit) begin
            nxt      = idle_stat(connected);
            start_n  = 1'b0;
            cancel_n = 1'b1;
            clr_n    = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat     <= '0;
            rbuf     <= '0;
            xbuf     <= '0;
            tx_start <= 1'b0;
            ev_set   <= '0;
            ev_clr   <= '0;
        end else begin
            stat     <= nxt;
            rbuf     <= nrb;
            xbuf     <= nxb;
            tx_start <= start_n;
            ev_set   <= set_n & ~clr_n;
            ev_clr   <= clr_n;
        end
    end
endmodule

// File: rtl/termline_skip.sv
module termline_skip
    import termline_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = 5
) (
    input  logic                 mode_b,
    input  logic [WORD_W-1:0]    word,
    input  logic [NUM_LINES-1:0] busy,
    input  logic [NUM_LINES-1:0] carrier,
    input  logic [NUM_LINES-1:0] dsr,
    output logic                 take
);
    logic [LINE_W-1:0] ln_b, ln_a;
    logic              req_xbe, req_cro, req_dsr;

    assign ln_b    = word[LINE_W-1:0];
    assign ln_a    = word[SKA_LINE_LSB +: LINE_W];
    assign req_xbe = word[SKB_XBE];
    assign req_cro = word[SKB_CRO];
    assign req_dsr = word[SKB_DSR];

    always_comb begin
        if (mode_b) begin
            take = (req_xbe || req_cro || req_dsr)
                && (!req_xbe || !busy[ln_b])
                && (!req_cro || carrier[ln_b])
                && (!req_dsr || dsr[ln_b]);
        end else begin
            take = !busy[ln_a];
        end
    end
endmodule

// File: rtl/termline_ctl.sv
module termline_ctl
    import termline_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = $clog2(NUM_LINES),
    parameter int TX_TICKS  = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_b,
    input  logic [NUM_LINES-1:0]          connected,
    input  logic                          cmd_valid,
    input  logic [WORD_W-1:0]             cmd_word,
    input  logic                          rx_valid,
    input  logic [LINE_W-1:0]             rx_line,
    input  logic [CHAR_W-1:0]             rx_char,
    input  logic                          rx_break,
    input  logic                          conn_valid,
    input  logic [LINE_W-1:0]             conn_line,
    input  logic                          lrst_valid,
    input  logic [LINE_W-1:0]             lrst_line,
    input  logic [LINE_W-1:0]             rd_line,
    input  logic                          rd_ack,
    output logic [5:0]                    rd_status,
    output logic [CHAR_W-1:0]             rd_rbuf,
    output logic [CHAR_W-1:0]             rd_xbuf,
    output logic                          rd_tx_busy,
    input  logic [WORD_W-1:0]             skip_word,
    output logic                          skip_take,
    output logic [NUM_LINES-1:0]          tx_start,
    output logic [NUM_LINES*EV_COUNT-1:0] evt_set,
    output logic [NUM_LINES*EV_COUNT-1:0] evt_clr
);
    line_stat_t          stat_v [NUM_LINES];
    logic [CHAR_W-1:0]   rbuf_v [NUM_LINES];
    logic [CHAR_W-1:0]   xbuf_v [NUM_LINES];
    logic [NUM_LINES-1:0] busy_v, car_v, dsr_v;
    logic [LINE_W-1:0]   cmd_line;
    cmd_t                cmd_d;
    logic [CHAR_W-1:0]   rx_eff;
    logic                unused_word_bits;

    assign cmd_line         = cmd_word[LINE_W-1:0];
    assign cmd_d            = decode_cmd(cmd_word);
    assign rx_eff           = rx_break ? '0 : rx_char;
    assign unused_word_bits = ^{cmd_word, skip_word};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        termline_lane #(.TICKS(TX_TICKS)) lane_i (
            .clk       (clk),
            .rst       (rst),
            .mode_b    (mode_b),
            .connected (connected[g]),
            .ack_hit   (rd_ack && (rd_line == LINE_W'(g))),
            .rx_hit    (rx_valid && (rx_line == LINE_W'(g))),
            .rx_char   (rx_eff),
            .conn_hit  (conn_valid && (conn_line == LINE_W'(g))),
            .cmd_hit   (cmd_valid && (cmd_line == LINE_W'(g))),
            .cmd       (cmd_d),
            .lrst_hit  (lrst_valid && (lrst_line == LINE_W'(g))),
            .stat      (stat_v[g]),
            .rbuf      (rbuf_v[g]),
            .xbuf      (xbuf_v[g]),
            .tx_busy   (busy_v[g]),
            .tx_start  (tx_start[g]),
            .ev_set    (evt_set[g*EV_COUNT +: EV_COUNT]),
            .ev_clr    (evt_clr[g*EV_COUNT +: EV_COUNT])
        );
        assign car_v[g] = stat_v[g].carrier;
        assign dsr_v[g] = stat_v[g].dsr;
    end

    assign rd_status  = stat_v[rd_line];
    assign rd_rbuf    = rbuf_v[rd_line];
    assign rd_xbuf    = xbuf_v[rd_line];
    assign rd_tx_busy = busy_v[rd_line];

    termline_skip #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) skip_i (
        .mode_b  (mode_b),
        .word    (skip_word),
        .busy    (busy_v),
        .carrier (car_v),
        .dsr     (dsr_v),
        .take    (skip_take)
    );
endmodule

// File: rtl/termline_ctl_chk.sv
module termline_ctl_chk
    import termline_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = 5
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          mode_b,
    input logic                          cmd_valid,
    input logic [WORD_W-1:0]             cmd_word,
    input logic                          rx_valid,
    input logic [LINE_W-1:0]             rx_line,
    input logic                          lrst_valid,
    input logic [LINE_W-1:0]             lrst_line,
    input logic [WORD_W-1:0]             skip_word,
    input logic                          skip_take,
    input logic [NUM_LINES-1:0]          tx_start,
    input logic [NUM_LINES*EV_COUNT-1:0] evt_set,
    input logic [NUM_LINES*EV_COUNT-1:0] evt_clr
);
    logic unused_chk_bits;
    assign unused_chk_bits = ^{cmd_word, skip_word};

    // R3
    mode_a_disable_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !mode_b && !cmd_word[CMD_CTL] |=> tx_start == '0);

    // R5
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_start));

    // R6
    rx_event_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !lrst_valid && !cmd_valid |=> evt_set[{$past(rx_line), 2'b00}]);

    // R10
    skip_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        mode_b && (skip_word[SKB_XBE:SKB_DSR] == 3'b000) |-> !skip_take);

    // R12
    line_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        lrst_valid |=> evt_clr[{$past(lrst_line), 2'b00} +: EV_COUNT] == 4'hF);
endmodule

bind termline_ctl termline_ctl_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_b     (mode_b),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .rx_valid   (rx_valid),
    .rx_line    (rx_line),
    .lrst_valid (lrst_valid),
    .lrst_line  (lrst_line),
    .skip_word  (skip_word),
    .skip_take  (skip_take),
    .tx_start   (tx_start),
    .evt_set    (evt_set),
    .evt_clr    (evt_clr)
);

// File: tb/termline_ctl_tb_top.sv
module termline_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL         = 32;
    localparam int TICKS      = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_b;
    logic [NL-1:0] connected;
    logic          cmd_valid;
    logic [23:0]   cmd_word;
    logic          rx_valid;
    logic [4:0]    rx_line;
    logic [7:0]    rx_char;
    logic          rx_break;
    logic          conn_valid;
    logic [4:0]    conn_line;
    logic          lrst_valid;
    logic [4:0]    lrst_line;
    logic [4:0]    rd_line;
    logic          rd_ack;
    logic [5:0]    rd_status;
    logic [7:0]    rd_rbuf, rd_xbuf;
    logic          rd_tx_busy;
    logic [23:0]   skip_word;
    logic          skip_take;
    logic [NL-1:0] tx_start;
    logic [NL*4-1:0] evt_set, evt_clr;

    termline_ctl #(.NUM_LINES(NL), .TX_TICKS(TICKS)) dut_i (
        .clk(clk), .rst(rst), .mode_b(mode_b), .connected(connected),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rx_valid(rx_valid), .rx_line(rx_line), .rx_char(rx_char), .rx_break(rx_break),
        .conn_valid(conn_valid), .conn_line(conn_line),
        .lrst_valid(lrst_valid), .lrst_line(lrst_line),
        .rd_line(rd_line), .rd_ack(rd_ack), .rd_status(rd_status),
        .rd_rbuf(rd_rbuf), .rd_xbuf(rd_xbuf), .rd_tx_busy(rd_tx_busy),
        .skip_word(skip_word), .skip_take(skip_take),
        .tx_start(tx_start), .evt_set(evt_set), .evt_clr(evt_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Bench model of the requirements
    logic [5:0]      m_stat [NL];
    logic [7:0]      m_rb   [NL];
    logic [7:0]      m_xb   [NL];
    int              m_tmr  [NL];
    logic [NL*4-1:0] m_set, m_clr;
    logic [NL-1:0]   m_start;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model_step();
        logic [NL-1:0] txc, killed;
        int l;
        for (int i = 0; i < NL; i++) begin
            txc[i] = 1'b0;
            killed[i] = 1'b0;
            if (m_tmr[i] > 0) begin
                m_tmr[i]--;
                if (m_tmr[i] == 0 && m_stat[i][1]) txc[i] = 1'b1;
            end
        end
        m_set = '0; m_clr = '0; m_start = '0;
        if (rd_ack) m_stat[rd_line][3:2] = 2'b00;
        if (rx_valid) begin
            if (m_stat[rx_line][2]) m_stat[rx_line][3] = 1'b1;
            else                    m_stat[rx_line][2] = 1'b1;
            m_rb[rx_line] = rx_break ? 8'h00 : rx_char;
            m_set[rx_line*4 + 0] = 1'b1;
        end
        if (conn_valid && mode_b && m_stat[conn_line][0]) begin
            m_stat[conn_line] = m_stat[conn_line] | 6'h30;
            m_set[conn_line*4 + 2] = 1'b1;
        end
        if (cmd_valid) begin
            l = int'(cmd_word[4:0]);
            if (!mode_b && !cmd_word[13]) begin
                m_stat[l][0] = 1'b0;
            end else if (mode_b && cmd_word[13]) begin
                if (connected[l]) begin
                    m_stat[l] = 6'h30;
                    m_tmr[l] = 0;
                    killed[l] = 1'b1;
                    m_clr[l*4 +: 3] = 3'b111;
                    m_set[l*4 + 3] = 1'b1;
                end else begin
                    m_stat[l][0] = 1'b0;
                end
            end else begin
                if (!cmd_word[15]) begin
                    m_xb[l] = cmd_word[23:16];
                    m_tmr[l] = TICKS;
                    killed[l] = 1'b1;
                    m_start[l] = 1'b1;
                end
                m_stat[l][1] = cmd_word[14];
                m_stat[l][0] = 1'b1;
            end
        end
        if (lrst_valid) begin
            l = int'(lrst_line);
            m_stat[l] = connected[l] ? 6'h30 : 6'h00;
            m_tmr[l] = 0;
            killed[l] = 1'b1;
            m_start[l] = 1'b0;
            m_clr[l*4 +: 4] = 4'hF;
        end
        for (int i = 0; i < NL; i++)
            if (txc[i] && !killed[i]) m_set[i*4 + 1] = 1'b1;
        m_set = m_set & ~m_clr;
    endfunction

    function automatic logic exp_skip(input logic mb, input logic [23:0] w);
        int l;
        logic busy;
        if (mb) begin
            l = int'(w[4:0]);
            busy = m_tmr[l] > 0;
            return (w[9:7] != 3'b000) && (!w[9] || !busy) &&
                   (!w[8] || m_stat[l][4]) && (!w[7] || m_stat[l][5]);
        end
        l = int'(w[11:7]);
        return !(m_tmr[l] > 0);
    endfunction

    task automatic clear_inputs();
        cmd_valid = 0; rx_valid = 0; conn_valid = 0; lrst_valid = 0; rd_ack = 0;
        rx_break = 0;
    endtask

    task automatic check_line(input int l);
        rd_line = l[4:0];
        #1;
        chk("R2 R6 R7 status", rd_status, m_stat[l]);
        chk("R6 receive buffer", rd_rbuf, m_rb[l]);
        chk("R2 R5 transmit buffer", rd_xbuf, m_xb[l]);
        chk("R2 busy", rd_tx_busy, m_tmr[l] > 0);
    endtask

    task automatic step(input int cl);
        logic [23:0] w;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 R5 tx_start", tx_start, m_start);
        chk("R4 R6 R8 R9 event set", evt_set, m_set);
        chk("R4 R12 event clear", evt_clr, m_clr);
        clear_inputs();
        check_line(cl);
        w = $urandom;
        w[4:3] = 2'b00;
        w[11:10] = 2'b00;
        skip_word = w;
        #1;
        chk(mode_b ? "R10 skip" : "R11 skip", skip_take, exp_skip(mode_b, w));
    endtask

    task automatic send_cmd(input int l, input logic [7:0] ch, input logic [2:0] ctl_bits);
        cmd_word = {ch, ctl_bits, 8'h00, l[4:0]};
        cmd_valid = 1;
        step(l);
    endtask

    task automatic rand_op();
        int k, l;
        logic [23:0] w;
        k = $urandom_range(0, 7);
        l = $urandom_range(0, 7);
        if ($urandom_range(0, 15) == 0) connected[l] = ~connected[l];
        case (k)
            0, 1: begin w = $urandom; w[4:0] = l[4:0]; cmd_word = w; cmd_valid = 1; end
            2: begin rx_valid = 1; rx_line = l[4:0]; rx_char = 8'($urandom);
                     rx_break = ($urandom_range(0, 5) == 0); end
            3: begin conn_valid = 1; conn_line = l[4:0]; end
            4: begin rd_ack = 1; rd_line = l[4:0]; end
            5: if ($urandom_range(0, 2) == 0) begin lrst_valid = 1; lrst_line = l[4:0]; end
            default: ;
        endcase
        step($urandom_range(0, 7));
    endtask

    task automatic sweep_all();
        for (int l = 0; l < NL; l++) step(l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5417));
        rst = 1; mode_b = 1; connected = '0;
        clear_inputs();
        cmd_word = '0; rx_line = '0; rx_char = '0; conn_line = '0; lrst_line = '0;
        rd_line = '0; skip_word = '0;
        for (int i = 0; i < NL; i++) begin
            m_stat[i] = '0; m_rb[i] = '0; m_xb[i] = '0; m_tmr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 reset tx_start", tx_start, 0);
        chk("R1 reset events", evt_set | evt_clr, 0);
        chk("R1 reset status line 0", rd_status, 0);
        sweep_all();

        // Mode B directed
        connected[3] = 1'b1;
        send_cmd(3, 8'h41, 3'b010);
        chk("R2 start pulse line 3", tx_start, 32'h8);
        chk("R2 xbuf", rd_xbuf, 8'h41);
        chk("R2 status enabled+txie", rd_status, 6'h03);
        for (int i = 1; i <= TICKS; i++) begin
            step(3);
            chk("R8 transmit event timing", evt_set[13], i == TICKS);
            chk("R2 busy window", rd_tx_busy, i < TICKS);
        end
        conn_valid = 1; conn_line = 3; step(3);
        chk("R9 carrier-on event", evt_set[14], 1'b1);
        chk("R9 carrier and dsr", rd_status, 6'h33);
        skip_word = 24'h000183; #1;
        chk("R10 carrier+dsr skip", skip_take, 1'b1);
        skip_word = 24'h000003; #1;
        chk("R10 no request no skip", skip_take, 1'b0);
        send_cmd(3, 8'h42, 3'b010);
        skip_word = 24'h000203; #1;
        chk("R10 busy blocks xbe skip", skip_take, 1'b0);
        rx_valid = 1; rx_line = 3; rx_char = 8'h55; step(3);
        chk("R6 pending set", rd_status[3:2], 2'b01);
        chk("R6 char stored", rd_rbuf, 8'h55);
        rx_valid = 1; rx_line = 3; rx_char = 8'h66; rx_break = 1; step(3);
        chk("R6 overrun set", rd_status[3:2], 2'b11);
        chk("R6 break as zero", rd_rbuf, 8'h00);
        rd_ack = 1; rd_line = 3; step(3);
        chk("R7 ack clears", rd_status[3:2], 2'b00);
        send_cmd(3, 8'h00, 3'b001);
        chk("R4 carrier-off set", evt_set[15:12], 4'h8);
        chk("R4 clears", evt_clr[15:12], 4'h7);
        chk("R4 status after hangup", rd_status, 6'h30);
        chk("R4 timer cancelled", rd_tx_busy, 1'b0);
        send_cmd(5, 8'h77, 3'b100);
        chk("R5 no start", tx_start, 0);
        chk("R5 status enabled", rd_status, 6'h01);
        chk("R5 xbuf untouched", rd_xbuf, 8'h00);
        lrst_valid = 1; lrst_line = 5; step(5);
        chk("R12 clears all kinds", evt_clr[23:20], 4'hF);
        chk("R12 status zero", rd_status, 6'h00);
        send_cmd(5, 8'h12, 3'b000);
        for (int i = 1; i <= TICKS; i++) begin
            step(5);
            chk("R8 no event with txie off", evt_set[21], 1'b0);
        end
        chk("R8 timer done", rd_tx_busy, 1'b0);

        // Mode A directed
        mode_b = 0;
        send_cmd(6, 8'h20, 3'b001);
        chk("R3 mode A enable start", tx_start, 32'h40);
        chk("R3 mode A status", rd_status, 6'h01);
        skip_word = 24'h000300; #1;
        chk("R11 busy no skip", skip_take, 1'b0);
        repeat (TICKS) step(6);
        skip_word = 24'h000300; #1;
        chk("R11 idle skip", skip_take, 1'b1);
        send_cmd(6, 8'h99, 3'b000);
        chk("R3 disable no start", tx_start, 0);
        chk("R3 disable status", rd_status, 6'h00);
        chk("R3 xbuf kept", rd_xbuf, 8'h20);
        connected[6] = 1'b1;
        conn_valid = 1; conn_line = 6; step(6);
        chk("R9 mode A connect no event", evt_set, 0);
        chk("R9 mode A connect no status", rd_status, 6'h00);

        // Random phases
        for (int i = 0; i < 1500; i++) rand_op();
        sweep_all();
        mode_b = 1;
        for (int i = 0; i < 1500; i++) rand_op();
        sweep_all();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule